// File: doc/BRIEF.md
# Configuration Address Translator

This block converts a processor access that lands in the downstream configuration window into a type-0 PCI configuration address. The low 16 bits of the processor offset and the low 16 bits of a mapping register are joined into one 32-bit combined address. The device number is the position of the lowest set bit in the one-hot device-select field of that combined address. The function and register numbers are taken from fixed fields. The result is then rebuilt around the current bus number, with the enable bit forced on.

Three kinds of request do not produce an address. A request whose mapping register asks for a non-type-0 cycle is rejected, and so is a request whose size is outside 1 to 4 bytes. A request whose device-select field is all zero is flagged as an error. A rejected read reports fill data made of ones for the requested number of bytes. The translation itself is combinational. All results are captured into registers and presented one cycle after the request, together with a one-cycle done strobe.

Top module: `cfg_addr_xlat`

## Requirements
- R1: The combined address has `mapReg[15:0]` in bits [31:16] and `cpuOffset[15:0]` in bits [15:0]. The device-select field is combined bits [31:11], so bit k of that field is combined bit 11+k.
- R2: The device number is the index of the lowest set bit in the device-select field, from 0 to 20. When several bits are set, the lowest one wins.
- R3: The function number is combined bits [10:8]. The register number is combined bits [7:2] and is placed at bits [7:2] of the output. Output bits [1:0] are 0.
- R4: An accepted address has bit 31 = 1 and bits [30:24] = 0. Bits [23:16] hold the bus number and bits [15:11] hold the device number.
- R5: `doneStb` is 1 exactly in the cycle after each cycle with `reqValid` = 1, and 0 otherwise. All result outputs update in that same cycle and then hold until the next request.
- R6: When `mapReg[16]` = 1, the request is rejected: `rejectFlag` = 1 and `cfgEn` = 0.
- R7: A rejected read (`reqWrite` = 0) with a size of 1 to 4 bytes returns `rdFill` with ones in its low 8×size bits (size 1 gives 0x000000FF, size 4 gives 0xFFFFFFFF). Every other request returns `rdFill` = 0.
- R8: A request that is not rejected but has an all-zero device-select field sets `errorFlag` = 1, with `cfgEn` = 0. Rejection takes precedence, so `errorFlag` and `rejectFlag` are never both 1.
- R9: `reqSize` values 1 to 4 are accepted. Values 0 and 5 to 7 cause a rejection, with `rdFill` = 0.
- R10: `cfgEn` is never 1 while `rejectFlag` or `errorFlag` is 1. After a request that was not accepted, `cfgAddr` reads 0.
- R11: While `rstN` = 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request in this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 3 | Access size in bytes |
| cpuOffset | input | 16 | Low processor offset within the window |
| mapReg | input | 32 | Mapping register (bits [15:0] upper half, bit 16 type select) |
| busNum | input | 8 | Current bus number |
| doneStb | output | 1 | Result strobe, one cycle after a request |
| cfgEn | output | 1 | Last request produced a valid address |
| cfgAddr | output | 32 | Translated configuration address |
| rejectFlag | output | 1 | Last request was rejected |
| errorFlag | output | 1 | Last request had an empty device-select field |
| rdFill | output | 32 | All-ones fill for a rejected read |

## Verification
The hardest cases to reach from the ports are those where two rules compete. One is a request that is both non-type-0 and has an empty device-select field, where rejection must win over the error flag. The other is a size outside 1 to 4 on an otherwise valid address. The vector table builds these directly from the mapping register and size inputs. It also places set bits at both ends of the device-select field, one in the offset half and one in the mapping half, and uses several set bits at once to confirm that the lowest index is chosen. Back-to-back requests and idle cycles then confirm that results hold and that the strobe pulses once per request.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;
  parameter int CFG_W     = 32;
  parameter int HALF_W    = 16;
  parameter int IDSEL_LO  = 11;
  parameter int IDSEL_W   = CFG_W - IDSEL_LO;
  parameter int DEV_W     = 5;
  parameter int FUNC_LO   = 8;
  parameter int FUNC_W    = 3;
  parameter int REG_LO    = 2;
  parameter int REG_W     = 6;
  parameter int BUS_W     = 8;
  parameter int TYPE_BIT  = 16;
  parameter int SIZE_W    = 3;
  parameter int MAX_BYTES = 4;
  parameter int DATA_W    = 8 * MAX_BYTES;
  parameter int PAD_W     = CFG_W - 1 - BUS_W - DEV_W - FUNC_W - REG_W - REG_LO;

  typedef struct packed {
    logic capture;
    logic addrOk;
    logic fillOk;
  } xlat_stb_t;
endpackage

// File: rtl/cfg_xlat_dp.sv
module cfg_xlat_dp
  import cfg_xlat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  xlat_stb_t            stb,
  input  logic [HALF_W-1:0]    cpuOffset,
  input  logic [HALF_W-1:0]    mapLow,
  input  logic [BUS_W-1:0]     busNum,
  input  logic [SIZE_W-1:0]    reqSize,
  output logic                 idselZero,
  output logic [CFG_W-1:0]     cfgAddr,
  output logic [DATA_W-1:0]    rdFill
);
  logic [CFG_W-1:0]   combined;
  logic [IDSEL_W-1:0] idsel;
  logic [DEV_W-1:0]   devNum;
  logic [CFG_W-1:0]   composed;
  logic [DATA_W-1:0]  fillMask;

  function automatic logic [DEV_W-1:0] lowIdx(input logic [IDSEL_W-1:0] v);
    logic [DEV_W-1:0] idx;
    idx = '0;
    for (int i = IDSEL_W - 1; i >= 0; i--) begin
      if (v[i]) idx = i[DEV_W-1:0];
    end
    return idx;
  endfunction

  always_comb begin
    combined  = {mapLow, cpuOffset};
    idsel     = combined[CFG_W-1:IDSEL_LO];
    idselZero = (idsel == '0);
    devNum    = lowIdx(idsel);
    composed  = {1'b1, {PAD_W{1'b0}}, busNum, devNum,
                 combined[FUNC_LO +: FUNC_W],
                 combined[REG_LO +: REG_W], {REG_LO{1'b0}}};
  end

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_fill
    assign fillMask[8*b +: 8] = {8{reqSize > SIZE_W'(b)}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAddr <= '0;
      rdFill  <= '0;
    end else if (stb.capture) begin
      cfgAddr <= stb.addrOk ? composed : '0;
      rdFill  <= stb.fillOk ? fillMask : '0;
    end
  end

  // R4
  addr_hdr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && stb.addrOk |=> cfgAddr[CFG_W-1] &&
      cfgAddr[CFG_W-2 -: PAD_W] == '0 &&
      cfgAddr[IDSEL_LO + DEV_W +: BUS_W] == $past(busNum));

  // R3
  low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgAddr[REG_LO-1:0] == '0);

  // R7
  fill_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && !stb.fillOk |=> rdFill == '0);
endmodule

// File: rtl/cfg_xlat_ctrl.sv
module cfg_xlat_ctrl
  import cfg_xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              typeSel,
  input  logic              idselZero,
  output xlat_stb_t         stb,
  output logic              doneStb,
  output logic              cfgEn,
  output logic              rejectFlag,
  output logic              errorFlag
);
  localparam logic [SIZE_W-1:0] MAX_SZ = SIZE_W'(MAX_BYTES);

  logic sizeOk;
  logic rejNow;
  logic errNow;

  always_comb begin
    sizeOk      = (reqSize != '0) && (reqSize <= MAX_SZ);
    rejNow      = typeSel || !sizeOk;
    errNow      = !rejNow && idselZero;
    stb.capture = reqValid;
    stb.addrOk  = reqValid && !rejNow && !errNow;
    stb.fillOk  = reqValid && rejNow && !reqWrite && sizeOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneStb    <= 1'b0;
      cfgEn      <= 1'b0;
      rejectFlag <= 1'b0;
      errorFlag  <= 1'b0;
    end else begin
      doneStb <= reqValid;
      if (reqValid) begin
        cfgEn      <= stb.addrOk;
        rejectFlag <= rejNow;
        errorFlag  <= errNow;
      end
    end
  end

  // R10
  en_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |-> !rejectFlag && !errorFlag);

  // R5
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> doneStb);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !doneStb && $stable(cfgEn) && $stable(rejectFlag));

  // R6
  type1_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && typeSel |=> rejectFlag && !cfgEn);

  // R8
  err_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(errorFlag && rejectFlag));
endmodule

// File: rtl/cfg_addr_xlat.sv
module cfg_addr_xlat
  import cfg_xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [HALF_W-1:0] cpuOffset,
  input  logic [CFG_W-1:0]  mapReg,
  input  logic [BUS_W-1:0]  busNum,
  output logic              doneStb,
  output logic              cfgEn,
  output logic [CFG_W-1:0]  cfgAddr,
  output logic              rejectFlag,
  output logic              errorFlag,
  output logic [DATA_W-1:0] rdFill
);
  xlat_stb_t stb;
  logic      idselZero;

  cfg_xlat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .typeSel    (mapReg[TYPE_BIT]),
    .idselZero  (idselZero),
    .stb        (stb),
    .doneStb    (doneStb),
    .cfgEn      (cfgEn),
    .rejectFlag (rejectFlag),
    .errorFlag  (errorFlag)
  );

  cfg_xlat_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cpuOffset (cpuOffset),
    .mapLow    (mapReg[HALF_W-1:0]),
    .busNum    (busNum),
    .reqSize   (reqSize),
    .idselZero (idselZero),
    .cfgAddr   (cfgAddr),
    .rdFill    (rdFill)
  );

  // R10
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb && !cfgEn |-> cfgAddr == '0);
endmodule

// File: tb/test_cfg_addr_xlat.sv
`timescale 1ns/1ps
module test_cfg_addr_xlat;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [2:0]  reqSize = 3'd0;
  logic [15:0] cpuOffset = '0;
  logic [31:0] mapReg = '0;
  logic [7:0]  busNum = '0;
  logic        doneStb, cfgEn, rejectFlag, errorFlag;
  logic [31:0] cfgAddr, rdFill;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_addr_xlat i_cfg_addr_xlat (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .cpuOffset(cpuOffset), .mapReg(mapReg),
    .busNum(busNum), .doneStb(doneStb), .cfgEn(cfgEn), .cfgAddr(cfgAddr),
    .rejectFlag(rejectFlag), .errorFlag(errorFlag), .rdFill(rdFill)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  size;
    logic [15:0] off;
    logic [31:0] map;
    logic [7:0]  bus;
    logic        expEn;
    logic        expRej;
    logic        expErr;
    logic [31:0] expAddr;
    logic [31:0] expFill;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd4, 16'h0234, 32'h0000_0001, 8'h00, 1'b1, 1'b0, 1'b0, 32'h8000_2A34, 32'h0}, // R1 R2 R3
    '{1'b1, 3'd1, 16'h0803, 32'h0000_0000, 8'h12, 1'b1, 1'b0, 1'b0, 32'h8012_0000, 32'h0}, // R3 R4
    '{1'b0, 3'd2, 16'hF7FF, 32'h0000_FFFF, 8'hAB, 1'b1, 1'b0, 1'b0, 32'h80AB_0FFC, 32'h0}, // R2 R3
    '{1'b0, 3'd3, 16'h0508, 32'h0000_8000, 8'hFF, 1'b1, 1'b0, 1'b0, 32'h80FF_A508, 32'h0}, // R2 R4
    '{1'b0, 3'd4, 16'h0000, 32'h0001_0001, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0, 32'hFFFF_FFFF}, // R6 R7
    '{1'b0, 3'd1, 16'h0000, 32'h0001_0000, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0000_00FF}, // R7
    '{1'b1, 3'd2, 16'h0000, 32'h0001_0020, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0},         // R7
    '{1'b0, 3'd4, 16'h07FC, 32'h0000_0000, 8'h05, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0},         // R8
    '{1'b0, 3'd0, 16'h0000, 32'h0000_0001, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0},         // R9
    '{1'b0, 3'd5, 16'h0000, 32'h0000_0001, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0},         // R9
    '{1'b0, 3'd3, 16'h0000, 32'h0001_0000, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0, 32'h00FF_FFFF}, // R8
    '{1'b1, 3'd4, 16'h3000, 32'h0000_0100, 8'h01, 1'b1, 1'b0, 1'b0, 32'h8001_0800, 32'h0}  // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    reqValid  = 1'b1;
    reqWrite  = v.wr;
    reqSize   = v.size;
    cpuOffset = v.off;
    mapReg    = v.map;
    busNum    = v.bus;
  endtask

  task automatic checkVec(input vec_t v, input int idx);
    chk($sformatf("R5 strobe v%0d", idx), {31'b0, doneStb}, 32'd1);
    chk($sformatf("R10 en v%0d", idx), {31'b0, cfgEn}, {31'b0, v.expEn});
    chk($sformatf("R6 rej v%0d", idx), {31'b0, rejectFlag}, {31'b0, v.expRej});
    chk($sformatf("R8 err v%0d", idx), {31'b0, errorFlag}, {31'b0, v.expErr});
    chk($sformatf("R4 addr v%0d", idx), cfgAddr, v.expAddr);
    chk($sformatf("R7 fill v%0d", idx), rdFill, v.expFill);
  endtask

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 doneStb", {31'b0, doneStb}, 32'd0);
    chk("R11 cfgEn", {31'b0, cfgEn}, 32'd0);
    chk("R11 cfgAddr", cfgAddr, 32'd0);
    chk("R11 flags", {30'b0, rejectFlag, errorFlag}, 32'd0);
    chk("R11 rdFill", rdFill, 32'd0);
    rstN = 1'b1;

    // table walk, one request followed by an idle cycle
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      reqValid = 1'b0;
      checkVec(VECS[i], i);
    end

    // R5: idle cycle drops the strobe, results hold
    @(negedge clk);
    chk("R5 idle strobe", {31'b0, doneStb}, 32'd0);
    chk("R5 hold addr", cfgAddr, VECS[NV-1].expAddr);
    chk("R5 hold en", {31'b0, cfgEn}, 32'd1);

    // R5: back-to-back requests, each result one cycle later
    @(negedge clk);
    drive(VECS[0]);
    @(negedge clk);
    checkVec(VECS[0], 100);
    drive(VECS[4]);
    @(negedge clk);
    checkVec(VECS[4], 104);
    drive(VECS[7]);
    @(negedge clk);
    reqValid = 1'b0;
    checkVec(VECS[7], 107);

    // R10: error then accepted address clears flags
    @(negedge clk);
    drive(VECS[3]);
    @(negedge clk);
    reqValid = 1'b0;
    checkVec(VECS[3], 103);

    // R11: reset after activity clears outputs
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R11 re-reset addr", cfgAddr, 32'd0);
    chk("R11 re-reset en", {31'b0, cfgEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule